// File: doc/BRIEF.md
# Reset Cause Recording Controller

This block merges a cold (power-on) reset and six warm reset sources into one system reset, and records in a 32-bit status word why resets happened. The warm sources are an external reset request pin, a debug reset request, a software reset control bit, two per-CPU watchdog timeouts and a system watchdog timeout. A cold reset wipes the status word so that only its cold-reset flag is set. A warm reset keeps the word and adds the flag of its own source, so the flags of successive warm resets build up until software clears them.

The status word also carries a software scratch byte and a 16-bit boot error code. Both survive warm resets. The error code can be written over the register bus or loaded by a boot sequencer through a dedicated strobe. Pin straps are latched only while the cold reset is asserted, and the boot-mode field taken from them is kept across every warm reset.

The system reset output clears downstream buffers and gates peripheral clocks. It is held low for a fixed number of cycles after the last request and is released on a clock edge.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_n` is low, the status word (register address 0) becomes 0x0040_0000 on the next clock edge, so bit 22 is the only bit set.
- R2: `strap_q` takes `strap_in` on every clock edge at which `por_n` is low, and holds its value at all other times, warm resets included. `boot_mode` is `strap_q[BOOT_W-1:0]`.
- R3: Each external request passes through a two-flop synchronizer and sets its cause bit on the third rising edge after it is first sampled high. The cause bits are: ext 21, debug 20, CPU1 watchdog 18, CPU0 watchdog 17, system watchdog 16. Bits that are already set stay set.
- R4: Requests that are sampled high in the same cycle set their cause bits in the same cycle.
- R5: `sys_rst_n` is low while `por_n` is low. It stays low for exactly HOLD_CYC (16) samples after the last cycle in which a request is seen or the cold reset ends, and it rises on a clock edge.
- R6: Writing a word with bit 0 set to address 1 starts a software reset. Bit 19 sets one edge after the write edge, and address 1 always reads back as 0.
- R7: A bus write to address 0 replaces bits 31:24 and 15:0. Bit 23 always reads as 0.
- R8: In a write to address 0, a 1 in bits 22:16 clears that cause bit and a 0 leaves it unchanged. A cause being set in the same cycle wins over the clear.
- R9: When `err_we` is high, `err_code` is loaded into bits 15:0. This takes priority over a bus write to the same field in the same cycle.
- R10: Bus addresses other than 0 and 1 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Cold (power-on) reset, active low, synchronous |
| ext_rst_req | input | 1 | External reset request pin, active high |
| dbg_rst_req | input | 1 | Debug reset request, active high |
| wdt_cpu0_req | input | 1 | CPU0 watchdog timeout |
| wdt_cpu1_req | input | 1 | CPU1 watchdog timeout |
| wdt_sys_req | input | 1 | System watchdog timeout |
| strap_in | input | STRAP_W | Pin-strap levels |
| strap_q | output | STRAP_W | Straps latched at cold reset |
| boot_mode | output | BOOT_W | Boot-mode field of the latched straps |
| reg_sel | input | 1 | Register bus select |
| reg_we | input | 1 | Register bus write enable |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| err_we | input | 1 | Boot error code load strobe |
| err_code | input | 16 | Boot error code |
| sys_rst_n | output | 1 | Merged system reset, active low |

## Verification
A cause flag set in the wrong cycle shows up when address 0 is read, one edge after the fault. A flag that is wrongly held or wrongly cleared remains visible there until the next cold reset, because nothing else in the block touches it. A hold counter that is off by one moves the rising edge of `sys_rst_n` by a cycle at the end of every reset. Stale or re-sampled straps appear on `strap_q` and `boot_mode` at the first warm reset. The bench's reference model compares all of these every cycle, so each fault is caught within a cycle of the point where it first reaches a port.

// File: rtl/rcc_pkg.sv
// Shared constants for the reset cause recording controller.
// Assumes a 32-bit status word whose cause bit positions are fixed,
// because software decodes them.
package rcc_pkg;
    localparam int N_CAUSE      = 6;          // warm causes, bits 21:16
    localparam int N_EXT_REQ    = 5;          // causes that arrive on pins
    localparam int CAUSE_LSB    = 16;
    localparam int POR_BIT      = 22;
    localparam int RSVD_BIT     = 23;
    localparam int IDX_SYS_WDT  = 0;
    localparam int IDX_CPU0_WDT = 1;
    localparam int IDX_CPU1_WDT = 2;
    localparam int IDX_SOFT     = 3;
    localparam int IDX_DEBUG    = 4;
    localparam int IDX_EXT      = 5;
    localparam logic [31:0] STATUS_COLD = 32'h0040_0000;
    localparam int ADDR_STATUS  = 0;
    localparam int ADDR_CTRL    = 1;

    typedef logic [N_CAUSE-1:0] cause_t;
endpackage

// File: rtl/rcc_sync.sv
// Multi-bit synchronizer chain: STAGES flops per bit.
// Assumes the bits are independent level requests, so bit skew
// between lanes does not matter.
module rcc_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: move each request one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!por_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rcc_hold.sv
// Reset stretcher. Loads HOLD_CYC during the cold reset or on any trigger,
// then counts down. The output is low while the count is non-zero.
// Assumes trig is synchronous to clk.
module rcc_hold #(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic trig,
    output logic sys_rst_n
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: reload on a request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt_q <= CNT_LOAD;
        end else if (trig) begin
            cnt_q <= CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign sys_rst_n = (cnt_q == '0);
endmodule

// File: rtl/rcc_bus.sv
// Register bus decoder. Produces the status write strobe and the
// self-clearing software reset pulse, and muxes the read data.
// Assumes a single-cycle write and combinational reads.
module rcc_bus
    import rcc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wdata_bit0,
    input  logic [31:0]       status,
    output logic              status_wr,
    output logic              soft_pulse,
    output logic [31:0]       reg_rdata
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADDR_CTRL);

    logic hit_status;
    logic hit_ctrl;

    // Purpose: address decode for both registers.
    always_comb begin
        hit_status = reg_sel && (reg_addr == A_STATUS);
        hit_ctrl   = reg_sel && (reg_addr == A_CTRL);
    end

    assign status_wr = hit_status && reg_we;

    // Purpose: one-cycle software reset pulse, clears itself.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            soft_pulse <= 1'b0;
        end else begin
            soft_pulse <= hit_ctrl && reg_we && wdata_bit0;
        end
    end

    // Purpose: read mux; the control register always reads zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STATUS) begin
            reg_rdata = status;
        end
    end
endmodule

// File: rtl/rcc_status.sv
// Status word: scratch byte, cause flags, boot error code.
// Cold reset loads STATUS_COLD. Set-by-cause wins over write-1-to-clear,
// and the error strobe wins over a bus write to the code field.
module rcc_status
    import rcc_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  cause_t      cause,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  logic        err_we,
    input  logic [15:0] err_code,
    output logic [31:0] status_q
);
    logic [31:0] nxt;
    logic        unused_wd23;

    assign unused_wd23 = wdata[RSVD_BIT];

    // Purpose: next value from bus write, error load and new causes.
    always_comb begin
        nxt = status_q;
        if (wr) begin
            nxt[31:24] = wdata[31:24];
            nxt[15:0]  = wdata[15:0];
            nxt[POR_BIT:CAUSE_LSB] = status_q[POR_BIT:CAUSE_LSB]
                                   & ~wdata[POR_BIT:CAUSE_LSB];
        end
        if (err_we) begin
            nxt[15:0] = err_code;
        end
        nxt[CAUSE_LSB +: N_CAUSE] = nxt[CAUSE_LSB +: N_CAUSE] | cause;
        nxt[RSVD_BIT] = 1'b0;
    end

    // Purpose: status register with cold-reset value.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            status_q <= STATUS_COLD;
        end else begin
            status_q <= nxt;
        end
    end
endmodule

// File: rtl/rst_cause_ctrl.sv
// Reset cause recording controller top. Synchronizes the warm reset
// requests, records their causes, stretches them into sys_rst_n, and
// latches the pin straps during the cold reset only.
// Assumes por_n is already synchronous to clk.
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int HOLD_CYC    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int STRAP_W     = 8,
    parameter int BOOT_W      = 3,
    parameter int ADDR_W      = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               ext_rst_req,
    input  logic               dbg_rst_req,
    input  logic               wdt_cpu0_req,
    input  logic               wdt_cpu1_req,
    input  logic               wdt_sys_req,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [STRAP_W-1:0] strap_q,
    output logic [BOOT_W-1:0]  boot_mode,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               err_we,
    input  logic [15:0]        err_code,
    output logic               sys_rst_n
);
    logic [N_EXT_REQ-1:0] req_raw;
    logic [N_EXT_REQ-1:0] req_sync;
    cause_t               cause;
    logic                 soft_pulse;
    logic                 status_wr;
    logic [31:0]          status_q;

    assign req_raw = {ext_rst_req, dbg_rst_req, wdt_cpu1_req,
                      wdt_cpu0_req, wdt_sys_req};

    rcc_sync #(.WIDTH(N_EXT_REQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d     (req_raw),
        .q     (req_sync)
    );

    // Purpose: place synchronized and software causes at their indices.
    always_comb begin
        cause               = '0;
        cause[IDX_SYS_WDT]  = req_sync[0];
        cause[IDX_CPU0_WDT] = req_sync[1];
        cause[IDX_CPU1_WDT] = req_sync[2];
        cause[IDX_DEBUG]    = req_sync[3];
        cause[IDX_EXT]      = req_sync[4];
        cause[IDX_SOFT]     = soft_pulse;
    end

    rcc_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk        (clk),
        .por_n      (por_n),
        .reg_sel    (reg_sel),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .wdata_bit0 (reg_wdata[0]),
        .status     (status_q),
        .status_wr  (status_wr),
        .soft_pulse (soft_pulse),
        .reg_rdata  (reg_rdata)
    );

    rcc_status u_status (
        .clk      (clk),
        .por_n    (por_n),
        .cause    (cause),
        .wr       (status_wr),
        .wdata    (reg_wdata),
        .err_we   (err_we),
        .err_code (err_code),
        .status_q (status_q)
    );

    rcc_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk       (clk),
        .por_n     (por_n),
        .trig      (|cause),
        .sys_rst_n (sys_rst_n)
    );

    // Purpose: sample the straps only while the cold reset is asserted.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            strap_q <= strap_in;
        end
    end

    assign boot_mode = strap_q[BOOT_W-1:0];
endmodule

// File: rtl/rcc_checker.sv
// Property checker for rst_cause_ctrl, attached with bind below.
// Assumes it sees the status register through the top's status_q.
module rcc_checker #(
    parameter int HOLD_CYC = 16,
    parameter int STRAP_W  = 8,
    parameter int ADDR_W   = 4
) (
    input logic               clk,
    input logic               por_n,
    input logic               sys_rst_n,
    input logic [31:0]        status_q,
    input logic [STRAP_W-1:0] strap_q,
    input logic               reg_sel,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_rdata
);
    int low_run;

    // Purpose: count consecutive low samples of sys_rst_n.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            low_run <= 0;
        end else if (!sys_rst_n) begin
            low_run <= low_run + 1;
        end else begin
            low_run <= 0;
        end
    end

    a_r1_cold_value: assert property (@(posedge clk)
        !por_n |=> (status_q == 32'h0040_0000));

    a_r5_low_in_cold: assert property (@(posedge clk)
        !por_n |=> !sys_rst_n);

    a_r5_min_hold: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && low_run != 0) |-> (low_run >= HOLD_CYC));

    a_r2_straps_kept: assert property (@(posedge clk) disable iff (!por_n)
        $past(por_n) |-> $stable(strap_q));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
        status_q[23] == 1'b0);

    a_r8_clear_only_by_write: assert property (@(posedge clk) disable iff (!por_n)
        ($past(por_n) && (($past(status_q[22:16]) & ~status_q[22:16]) != 7'd0))
        |-> $past(reg_sel && reg_we && reg_addr == '0));

    a_r6_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!por_n)
        (reg_addr == ADDR_W'(1)) |-> (reg_rdata == 32'd0));
endmodule

bind rst_cause_ctrl rcc_checker #(
    .HOLD_CYC (HOLD_CYC),
    .STRAP_W  (STRAP_W),
    .ADDR_W   (ADDR_W)
) u_rcc_checker (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .status_q  (status_q),
    .strap_q   (strap_q),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/test_rst_cause_ctrl.sv
module test_rst_cause_ctrl;
    localparam int STRAP_W = 8;
    localparam int BOOT_W  = 3;
    localparam int ADDR_W  = 4;
    localparam int HOLD    = 16;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_rst_req = 0, dbg_rst_req = 0, wdt_cpu0_req = 0;
    logic wdt_cpu1_req = 0, wdt_sys_req = 0;
    logic [STRAP_W-1:0] strap_in = 8'h5A;
    logic [STRAP_W-1:0] strap_q;
    logic [BOOT_W-1:0]  boot_mode;
    logic reg_sel = 0, reg_we = 0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic err_we = 0;
    logic [15:0] err_code = '0;
    logic sys_rst_n;

    always #2 clk = ~clk;   // 250 MHz

    rst_cause_ctrl i_rst_cause_ctrl (
        .clk(clk), .por_n(por_n),
        .ext_rst_req(ext_rst_req), .dbg_rst_req(dbg_rst_req),
        .wdt_cpu0_req(wdt_cpu0_req), .wdt_cpu1_req(wdt_cpu1_req),
        .wdt_sys_req(wdt_sys_req),
        .strap_in(strap_in), .strap_q(strap_q), .boot_mode(boot_mode),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_we(err_we), .err_code(err_code), .sys_rst_n(sys_rst_n)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    string phase = "R1";

    // ---------------- reference model ----------------
    logic [31:0] m_status;
    int          m_cnt;
    logic [STRAP_W-1:0] m_straps;
    logic [5:0]  m_pipe[$];
    logic        m_soft;
    bit          m_valid = 0;

    always @(posedge clk) begin
        logic [5:0] causes;
        logic [5:0] incoming;
        if (!por_n) begin
            m_status = 32'h0040_0000;
            m_cnt    = HOLD;
            m_straps = strap_in;
            m_pipe   = {6'd0, 6'd0};
            m_soft   = 0;
        end else begin
            causes = m_pipe[0];
            if (m_soft) causes[3] = 1'b1;
            if (reg_sel && reg_we && reg_addr == 0) begin
                m_status[31:24] = reg_wdata[31:24];
                m_status[15:0]  = reg_wdata[15:0];
                m_status[22:16] = m_status[22:16] & ~reg_wdata[22:16];
            end
            if (err_we) m_status[15:0] = err_code;
            m_status[21:16] = m_status[21:16] | causes;
            if (causes != 0) m_cnt = HOLD;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_soft = reg_sel && reg_we && reg_addr == 1 && reg_wdata[0];
            incoming = {ext_rst_req, dbg_rst_req, 1'b0,
                        wdt_cpu1_req, wdt_cpu0_req, wdt_sys_req};
            void'(m_pipe.pop_front());
            m_pipe.push_back(incoming);
        end
        m_valid = 1;
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Per-cycle comparison against the model, plus the watchdog.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            finish_run();
        end
        if (m_valid) begin
            chk(phase, "rdata", reg_rdata,
                (reg_addr == 0) ? m_status : 32'd0);
            chk(phase, "sys_rst_n", {31'd0, sys_rst_n}, {31'd0, m_cnt == 0});
            chk("R2", "strap_q", {24'd0, strap_q}, {24'd0, m_straps});
            chk("R2", "boot_mode", {29'd0, boot_mode}, {29'd0, m_straps[2:0]});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic edge_drive();
        @(posedge clk); #1;
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        edge_drive();
        reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        edge_drive();
        reg_sel = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    endtask

    task automatic read_chk(string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        edge_drive();
        reg_addr = a;
        @(negedge clk); #0.5;
        chk(tag, "read", reg_rdata, exp);
        edge_drive();
        reg_addr = 0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) edge_drive();
    endtask

    // Count low samples of sys_rst_n over a window after a trigger.
    task automatic count_low(string tag, int window);
        int lows = 0;
        for (int i = 0; i < window; i++) begin
            @(negedge clk); #0.5;
            if (!sys_rst_n) lows++;
        end
        chk(tag, "low samples", lows, HOLD);
    endtask

    initial begin
        // Cold reset
        phase = "R1";
        wait_cyc(4);
        @(negedge clk); #0.5;
        chk("R1", "status in cold", reg_rdata, 32'h0040_0000);
        chk("R5", "low in cold", {31'd0, sys_rst_n}, 32'd0);
        edge_drive();
        por_n = 1;
        phase = "R5";
        count_low("R5", 30);
        chk("R2", "straps latched", {24'd0, strap_q}, 32'h5A);
        chk("R2", "boot mode", {29'd0, boot_mode}, 32'd2);

        // Scratch byte and error field written over the bus
        phase = "R7";
        bus_wr(0, 32'hA500_1234);
        read_chk("R7", 0, 32'hA540_1234);

        // External pulse; straps change but must not be taken
        phase = "R3";
        strap_in = 8'h33;
        edge_drive();
        ext_rst_req = 1;
        edge_drive();
        ext_rst_req = 0;
        count_low("R3", 30);
        read_chk("R3", 0, 32'hA560_1234);
        chk("R2", "straps kept on warm", {24'd0, strap_q}, 32'h5A);

        // Two sources together
        phase = "R4";
        edge_drive();
        dbg_rst_req = 1; wdt_cpu0_req = 1;
        edge_drive();
        dbg_rst_req = 0; wdt_cpu0_req = 0;
        wait_cyc(25);
        read_chk("R4", 0, 32'hA572_1234);

        // Software reset
        phase = "R6";
        bus_wr(1, 32'h0000_0001);
        read_chk("R6", 1, 32'd0);
        wait_cyc(20);
        read_chk("R6", 0, 32'hA57A_1234);

        // CPU1 watchdog
        phase = "R3";
        edge_drive();
        wdt_cpu1_req = 1;
        edge_drive();
        wdt_cpu1_req = 0;
        wait_cyc(25);
        read_chk("R3", 0, 32'hA57E_1234);

        // Reserved bit cannot be written
        phase = "R7";
        bus_wr(0, 32'h0080_0000);
        read_chk("R7", 0, 32'h007E_0000);

        // Write-1-to-clear of the cold flag
        phase = "R8";
        bus_wr(0, 32'h0040_0000);
        read_chk("R8", 0, 32'h003E_0000);

        // Error strobe wins over bus write of the same field
        phase = "R9";
        edge_drive();
        err_we = 1; err_code = 16'hBEEF;
        reg_sel = 1; reg_we = 1; reg_addr = 0; reg_wdata = 32'h0000_1111;
        edge_drive();
        err_we = 0; reg_sel = 0; reg_we = 0; reg_wdata = 0;
        read_chk("R9", 0, 32'h003E_BEEF);

        // Set wins over clear while the system watchdog is held high
        phase = "R8";
        edge_drive();
        wdt_sys_req = 1;
        wait_cyc(4);
        bus_wr(0, 32'h0001_BEEF);
        read_chk("R8", 0, 32'h003F_BEEF);
        edge_drive();
        wdt_sys_req = 0;
        wait_cyc(25);

        // Unmapped address
        phase = "R10";
        bus_wr(2, 32'hFFFF_FFFF);
        read_chk("R10", 2, 32'd0);
        read_chk("R10", 0, 32'h003F_BEEF);

        // Second cold reset takes new straps and wipes the status word
        phase = "R1";
        strap_in = 8'h81;
        edge_drive();
        por_n = 0;
        wait_cyc(3);
        por_n = 1;
        wait_cyc(2);
        read_chk("R1", 0, 32'h0040_0000);
        chk("R2", "straps after cold", {24'd0, strap_q}, 32'h81);
        chk("R2", "boot after cold", {29'd0, boot_mode}, 32'd1);
        wait_cyc(20);

        finish_run();
    end
endmodule